// File: doc/BRIEF.md
# Modem Status Register Logic

This block watches the four active-low modem handshake inputs of a serial port (clear-to-send, data-set-ready, ring indicator and carrier detect) and presents them as an 8-bit status word. The upper nibble shows the present state of each line as an active-high bit. The lower nibble holds sticky change flags, which the CPU clears by reading the word. A read is a one-cycle `rd_strobe` from the bus decoder. A loop-back mode replaces the four pins with four modem-control output bits from the same port, so software can test the path without external wiring.

Any set change flag raises an interrupt request, which an enable input gates. The block also drives a transmit hold signal for hardware flow control. A small three-state machine (`FLOW_RUN`, `FLOW_DRAIN`, `FLOW_HELD`) keeps track of whether a character is still in flight when the far end withdraws clear-to-send. The transmitter finishes that character and starts no new one while the hold is high.

The flow state machine has these transitions:
- `FLOW_RUN` to `FLOW_DRAIN`: a stop is requested and the transmitter is busy.
- `FLOW_RUN` to `FLOW_HELD`: a stop is requested and the transmitter is idle.
- `FLOW_DRAIN` to `FLOW_HELD`: the transmitter goes idle.
- `FLOW_DRAIN` to `FLOW_RUN` and `FLOW_HELD` to `FLOW_RUN`: the stop request is withdrawn.

A stop request means `flow_en` is 1 and the clear-to-send status bit is 0.

Top module: `modem_status_unit`

## Requirements
- R1: In normal mode, `status_q[7]`, `[6]`, `[5]` and `[4]` hold the complement of `dcd_n`, `ri_n`, `dsr_n` and `cts_n` respectively. A pin change shows in `status_q` after the third rising clock edge that follows it: two synchronizer flops, then the status register.
- R2: While `loop_en` is 1, `status_q[7:4]` takes `{out2_bit, out1_bit, dtr_bit, rts_bit}` at the next rising edge, and the pins have no effect.
- R3: `status_q[3]`, `[1]` and `[0]` are set when status bit 7, 5 or 4, respectively, changes in either direction. They stay set until a read.
- R4: `status_q[2]` is set only when status bit 6 changes from 0 to 1. A change from 1 to 0 leaves it unchanged.
- R5: A cycle with `rd_strobe` = 1 clears all four change flags at the next edge, unless R6 applies.
- R6: A change that lands on the same edge as the clearing read leaves its flag set.
- R7: `msi_irq` is 1 exactly when `msi_en` is 1 and at least one change flag is set.
- R8: When `flow_en` is 1 and `status_q[4]` is 0, `tx_hold` rises at the next edge. The state machine stays in `FLOW_DRAIN` while `tx_busy` is 1 and moves to `FLOW_HELD` once it is 0. `tx_hold` falls one edge after the stop request is withdrawn.
- R9: After reset, `status_q` is 8'h00, `msi_irq` is 0 and `tx_hold` is 0. The synchronizers reset to the inactive (high) pin level.
- R10: Entering or leaving loop-back is flagged like any other change when the selected source differs from the previous line state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cts_n | input | 1 | Clear-to-send pin, active low, asynchronous |
| dsr_n | input | 1 | Data-set-ready pin, active low, asynchronous |
| ri_n | input | 1 | Ring-indicator pin, active low, asynchronous |
| dcd_n | input | 1 | Carrier-detect pin, active low, asynchronous |
| loop_en | input | 1 | Loop-back select |
| rts_bit | input | 1 | Modem-control output bit fed to bit 4 in loop-back |
| dtr_bit | input | 1 | Modem-control output bit fed to bit 5 in loop-back |
| out1_bit | input | 1 | Modem-control output bit fed to bit 6 in loop-back |
| out2_bit | input | 1 | Modem-control output bit fed to bit 7 in loop-back |
| rd_strobe | input | 1 | One-cycle CPU read of the status word |
| msi_en | input | 1 | Modem status interrupt enable |
| flow_en | input | 1 | Hardware flow control enable |
| tx_busy | input | 1 | Transmitter is sending a character |
| status_q | output | 8 | Line states [7:4], change flags [3:0] |
| msi_irq | output | 1 | Modem status interrupt request |
| tx_hold | output | 1 | Do not start a new character |

## Verification
The assertions assume three things about the inputs. `tx_busy` comes from a transmitter that drops it only at a character boundary. `rd_strobe` reflects real reads. The loop-back source bits are synchronous to `clk`, whereas the pins may change at any time.

The stimulus drives every input on the falling edge. It toggles each pin rarely, so that edges reach the status register separated by quiet cycles and can be identified. It also issues reads, switches loop-back and moves `tx_busy` at random with a fixed seed. The directed cases place a pin change on the same edge as a read, cover both directions of the ring line, and stop the transmitter while a character is in flight.

// File: rtl/msr_pkg.sv
package msr_pkg;
    localparam int LINE_W  = 4;
    localparam int IDX_CTS = 0;
    localparam int IDX_DSR = 1;
    localparam int IDX_RI  = 2;
    localparam int IDX_DCD = 3;
    localparam int STAT_W  = 2 * LINE_W;

    typedef enum logic [1:0] {
        FLOW_RUN   = 2'd0,
        FLOW_DRAIN = 2'd1,
        FLOW_HELD  = 2'd2
    } flow_state_e;
endpackage

// File: rtl/msr_sync.sv
module msr_sync #(
    parameter int WIDTH   = 4,
    parameter int STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [STAGES-1:0][WIDTH-1:0] pipe_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q[0] <= RST_VAL;
        else        pipe_q[0] <= async_in;
    end

    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe_q[g] <= RST_VAL;
            else        pipe_q[g] <= pipe_q[g-1];
        end
    end

    assign sync_out = pipe_q[STAGES-1];
endmodule

// File: rtl/msr_change_track.sv
module msr_change_track
    import msr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LINE_W-1:0] pin_sync_n,
    input  logic              loop_en,
    input  logic [LINE_W-1:0] loop_src,
    input  logic              rd_strobe,
    output logic [LINE_W-1:0] line_q,
    output logic [LINE_W-1:0] flag_q
);
    logic [LINE_W-1:0] line_next;
    logic [LINE_W-1:0] delta;
    logic [LINE_W-1:0] flag_next;

    assign line_next = loop_en ? loop_src : ~pin_sync_n;

    for (genvar i = 0; i < LINE_W; i++) begin : g_delta
        if (i == IDX_RI) begin : g_rise
            assign delta[i] = line_next[i] & ~line_q[i];
        end else begin : g_toggle
            assign delta[i] = line_next[i] ^ line_q[i];
        end
    end

    always_comb begin
        if (rd_strobe) flag_next = delta;
        else           flag_next = flag_q | delta;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_q <= '0;
            flag_q <= '0;
        end else begin
            line_q <= line_next;
            flag_q <= flag_next;
        end
    end

    // R3: a change flag stays set without a read
    p_sticky_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q[IDX_DCD] && !rd_strobe) |=> flag_q[IDX_DCD]);

    // R4: ring flag rises only together with a 0->1 ring status
    p_ri_rise_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q[IDX_RI]) |-> $rose(line_q[IDX_RI]));

    // R5: a read with no coinciding change empties the flags
    p_read_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && (line_next == line_q)) |=> (flag_q == '0));

    // R2: loop-back status follows the internal bits one edge later
    p_loop_map_r2: assert property (@(posedge clk) disable iff (!rst_n)
        loop_en |=> (line_q == $past(loop_src)));
endmodule

// File: rtl/msr_flow_fsm.sv
module msr_flow_fsm
    import msr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic flow_en,
    input  logic cts_on,
    input  logic tx_busy,
    output logic tx_hold
);
    flow_state_e state_q, state_d;
    logic        stop_req;

    assign stop_req = flow_en && !cts_on;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FLOW_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLOW_RUN: begin
                if (stop_req) state_d = tx_busy ? FLOW_DRAIN : FLOW_HELD;
            end
            FLOW_DRAIN: begin
                if (!stop_req)     state_d = FLOW_RUN;
                else if (!tx_busy) state_d = FLOW_HELD;
            end
            FLOW_HELD: begin
                if (!stop_req) state_d = FLOW_RUN;
            end
            default: state_d = FLOW_RUN;
        endcase
    end

    always_comb begin
        tx_hold = 1'b0;
        unique case (state_q)
            FLOW_RUN:   tx_hold = 1'b0;
            FLOW_DRAIN: tx_hold = 1'b1;
            FLOW_HELD:  tx_hold = 1'b1;
            default:    tx_hold = 1'b0;
        endcase
    end

    // R8: the drain phase ends in the held state only when the character is done
    p_drain_exit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q == FLOW_DRAIN) && state_q == FLOW_HELD) |-> !$past(tx_busy));

    // R8: hold only rises in answer to a stop request
    p_hold_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_hold) |-> $past(flow_en && !cts_on));
endmodule

// File: rtl/modem_status_unit.sv
module modem_status_unit
    import msr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cts_n,
    input  logic              dsr_n,
    input  logic              ri_n,
    input  logic              dcd_n,
    input  logic              loop_en,
    input  logic              rts_bit,
    input  logic              dtr_bit,
    input  logic              out1_bit,
    input  logic              out2_bit,
    input  logic              rd_strobe,
    input  logic              msi_en,
    input  logic              flow_en,
    input  logic              tx_busy,
    output logic [STAT_W-1:0] status_q,
    output logic              msi_irq,
    output logic              tx_hold
);
    logic [LINE_W-1:0] pins_n;
    logic [LINE_W-1:0] pins_sync_n;
    logic [LINE_W-1:0] loop_src;
    logic [LINE_W-1:0] line_q;
    logic [LINE_W-1:0] flag_q;

    assign pins_n   = {dcd_n, ri_n, dsr_n, cts_n};
    assign loop_src = {out2_bit, out1_bit, dtr_bit, rts_bit};

    msr_sync #(
        .WIDTH  (LINE_W),
        .STAGES (SYNC_STAGES),
        .RST_VAL('1)
    ) i_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_in(pins_n),
        .sync_out(pins_sync_n)
    );

    msr_change_track i_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_sync_n(pins_sync_n),
        .loop_en   (loop_en),
        .loop_src  (loop_src),
        .rd_strobe (rd_strobe),
        .line_q    (line_q),
        .flag_q    (flag_q)
    );

    msr_flow_fsm i_flow (
        .clk    (clk),
        .rst_n  (rst_n),
        .flow_en(flow_en),
        .cts_on (line_q[IDX_CTS]),
        .tx_busy(tx_busy),
        .tx_hold(tx_hold)
    );

    assign status_q = {line_q, flag_q};
    assign msi_irq  = msi_en && (|flag_q);

    // R7: a request never rises while the enable is low
    p_irq_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(msi_irq) |-> msi_en);

    // R6: a flag set by a change on a read edge survives that read
    p_keep_on_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && !loop_en && !$stable(pins_sync_n[IDX_DCD])) |=> status_q[IDX_DCD]);
endmodule

// File: tb/test_modem_status_unit.sv
module test_modem_status_unit;
    logic clk = 1'b0;
    logic rst_n;
    logic cts_n, dsr_n, ri_n, dcd_n;
    logic loop_en, rts_bit, dtr_bit, out1_bit, out2_bit;
    logic rd_strobe, msi_en, flow_en, tx_busy;
    logic [7:0] status_q;
    logic msi_irq, tx_hold;

    int total = 0;
    int bad   = 0;

    logic [3:0] m_s1, m_s2, m_line, m_flag;
    int         m_state;

    always #5 clk = ~clk;

    modem_status_unit i_modem_status_unit (
        .clk(clk), .rst_n(rst_n),
        .cts_n(cts_n), .dsr_n(dsr_n), .ri_n(ri_n), .dcd_n(dcd_n),
        .loop_en(loop_en), .rts_bit(rts_bit), .dtr_bit(dtr_bit),
        .out1_bit(out1_bit), .out2_bit(out2_bit),
        .rd_strobe(rd_strobe), .msi_en(msi_en), .flow_en(flow_en),
        .tx_busy(tx_busy),
        .status_q(status_q), .msi_irq(msi_irq), .tx_hold(tx_hold)
    );

    function automatic logic [3:0] f_delta(logic [3:0] nw, logic [3:0] old);
        return {nw[3] ^ old[3], nw[2] & ~old[2], nw[1] ^ old[1], nw[0] ^ old[0]};
    endfunction

    function automatic int f_next_state(int st, bit stop, bit busy);
        case (st)
            0: return stop ? (busy ? 1 : 2) : 0;
            1: return !stop ? 0 : (!busy ? 2 : 1);
            default: return stop ? 2 : 0;
        endcase
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic step();
        logic [3:0] src;
        @(posedge clk);
        src = loop_en ? {out2_bit, out1_bit, dtr_bit, rts_bit} : ~m_s2;
        m_state = f_next_state(m_state, flow_en && !m_line[0], tx_busy);
        m_flag  = rd_strobe ? f_delta(src, m_line) : (m_flag | f_delta(src, m_line));
        m_line  = src;
        m_s2    = m_s1;
        m_s1    = {dcd_n, ri_n, dsr_n, cts_n};
        @(negedge clk);
        check("R1 R2 R3 R4 R5 status", {24'd0, status_q}, {24'd0, m_line, m_flag});
        check("R7 irq", {31'd0, msi_irq}, {31'd0, msi_en && (|m_flag)});
        check("R8 hold", {31'd0, tx_hold}, {31'd0, m_state != 0});
    endtask

    task automatic steps(int n);
        for (int k = 0; k < n; k++) step();
    endtask

    task automatic do_read();
        rd_strobe = 1'b1;
        step();
        rd_strobe = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog act=running exp=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        rst_n = 1'b0;
        {cts_n, dsr_n, ri_n, dcd_n} = 4'hF;
        {loop_en, rts_bit, dtr_bit, out1_bit, out2_bit} = '0;
        {rd_strobe, msi_en, flow_en, tx_busy} = '0;
        m_s1 = 4'hF; m_s2 = 4'hF; m_line = 4'h0; m_flag = 4'h0; m_state = 0;
        repeat (3) @(negedge clk);
        check("R9 reset status", {24'd0, status_q}, 32'h00);
        check("R9 reset irq", {31'd0, msi_irq}, 32'd0);
        check("R9 reset hold", {31'd0, tx_hold}, 32'd0);
        rst_n = 1'b1;
        step();

        // R1 R3 R7: carrier detect asserted, visible after three edges
        msi_en = 1'b1;
        dcd_n  = 1'b0;
        steps(2);
        check("R1 latency", {24'd0, status_q}, 32'h00);
        step();
        check("R1 R3 dcd", {24'd0, status_q}, 32'h88);
        check("R7 irq on", {31'd0, msi_irq}, 32'd1);

        // R5: read clears the flags
        do_read();
        check("R5 clear", {24'd0, status_q}, 32'h80);
        check("R7 irq off", {31'd0, msi_irq}, 32'd0);

        // R4: ring rise flags, ring fall does not
        ri_n = 1'b0;
        steps(3);
        check("R4 ri rise", {24'd0, status_q}, 32'hC4);
        do_read();
        ri_n = 1'b1;
        steps(3);
        check("R4 ri fall", {24'd0, status_q}, 32'h80);

        // R6: change lands on the read edge
        cts_n = 1'b0;
        steps(2);
        do_read();
        check("R6 keep", {24'd0, status_q}, 32'h91);
        do_read();

        // R8: stop while a character is in flight
        flow_en = 1'b1;
        tx_busy = 1'b1;
        cts_n   = 1'b1;
        steps(3);
        check("R8 pre", {31'd0, tx_hold}, 32'd0);
        step();
        check("R8 drain hold", {31'd0, tx_hold}, 32'd1);
        tx_busy = 1'b0;
        steps(2);
        check("R8 held", {31'd0, tx_hold}, 32'd1);
        cts_n = 1'b0;
        steps(3);
        check("R8 still held", {31'd0, tx_hold}, 32'd1);
        step();
        check("R8 release", {31'd0, tx_hold}, 32'd0);
        do_read();

        // R10: entering loop-back with all sources low flags DCD and CTS
        loop_en = 1'b1;
        step();
        check("R10 loop entry", {24'd0, status_q}, 32'h09);
        do_read();

        // R2: cross-mapping and pins ignored
        {out2_bit, out1_bit, dtr_bit, rts_bit} = 4'b0110;
        step();
        check("R2 map", {28'd0, status_q[7:4]}, 32'h6);
        do_read();
        dcd_n = 1'b1; dsr_n = 1'b0;
        steps(4);
        check("R2 pins ignored", {24'd0, status_q}, 32'h60);
        loop_en = 1'b0;
        step();

        // random mix
        for (int c = 0; c < 3000; c++) begin
            if ($urandom_range(0, 9) == 0) cts_n = ~cts_n;
            if ($urandom_range(0, 9) == 0) dsr_n = ~dsr_n;
            if ($urandom_range(0, 9) == 0) ri_n  = ~ri_n;
            if ($urandom_range(0, 9) == 0) dcd_n = ~dcd_n;
            if ($urandom_range(0, 40) == 0) loop_en = ~loop_en;
            if ($urandom_range(0, 5) == 0)
                {out2_bit, out1_bit, dtr_bit, rts_bit} = 4'($urandom_range(0, 15));
            rd_strobe = ($urandom_range(0, 7) == 0);
            if ($urandom_range(0, 30) == 0) msi_en  = ~msi_en;
            if ($urandom_range(0, 30) == 0) flow_en = ~flow_en;
            if ($urandom_range(0, 6) == 0)  tx_busy = ~tx_busy;
            step();
        end
        rd_strobe = 1'b0;

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule